// File: doc/BRIEF.md
# Multi-Cycle Sequencing Controller

This block is the sequencing half of a small processor whose instructions and data live in one shared memory. It holds a control-state register and the combinational control logic that, from the current state, the opcode in the instruction register and the N and Z status bits, produces the control word for the datapath each cycle. Every instruction starts with a fetch state that addresses memory from the program counter and loads the instruction register. One or two execute states follow, and after the last of them the controller returns to fetch.

The control word drives the memory-address source select and the instruction-register load. It also carries a two-bit program-counter command, the function-unit and bus selects, and the register-file and memory write enables. Three register-address selectors sit on the control word's register fields. Each one passes either an instruction field widened with a zero top bit or a controller-supplied address. Only a controller-supplied address can reach the upper half of the 16-entry file, where the temporaries live. The two-step load-indirect instruction uses the first of these temporaries to hold the intermediate address.

Top module: `seq_ctrl_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller in the fetch state, even in the middle of an instruction. In the following cycle `ir_load`=1, `addr_from_pc`=1, `pc_op`=00, and `rf_we`=`mem_we`=0.
- R2: In fetch, `ir_load`=1, `addr_from_pc`=1 (memory addressed from the PC; 0 means bus A), `pc_op`=00, `b_const`=`fn_sel`=`d_from_mem`=`rf_we`=`mem_we`=0, and `rf_dst/rf_a/rf_b` equal `{0,dr}/{0,sa}/{0,sb}`. `ir_load` is high for exactly one cycle per instruction, and the next cycle is execute.
- R3: Each register address is 4 bits. When the controller's select field has top bit 0, the address is `{0, field}` of the instruction (dr for the destination, sa for A, sb for B). When the top bit is 1, the address is the select field itself, which is the only way to reach registers 8 to 15.
- R4: Opcode 0000010 (add) gives one execute cycle with `rf_dst`={0,dr}, `rf_a`={0,sa}, `rf_b`={0,sb}, `b_const`=0, `fn_sel`=0010, `d_from_mem`=0, `rf_we`=1, `mem_we`=0, `addr_from_pc`=0 and `pc_op`=01.
- R5: Opcode 1000010 (add immediate) is the same as R4 but with `b_const`=1.
- R6: Opcode 0010000 (load) gives one execute cycle with `addr_from_pc`=0, `d_from_mem`=1, `rf_we`=1, `fn_sel`=0000, `b_const`=0, `mem_we`=0 and `pc_op`=01.
- R7: Opcode 0100000 (store) gives one execute cycle with `addr_from_pc`=0, `mem_we`=1, `rf_we`=0, `b_const`=0, `fn_sel`=0000 and `pc_op`=01. `rf_we` and `mem_we` are never high together.
- R8: Opcode 0010001 (load indirect) takes two execute cycles. In the first, `rf_dst`=8, `rf_a`={0,sa}, `addr_from_pc`=0, `d_from_mem`=1, `rf_we`=1 and `pc_op`=00. In the second, `rf_a`=8, `rf_dst`={0,dr}, `addr_from_pc`=0, `d_from_mem`=1, `rf_we`=1 and `pc_op`=01. Fetch follows.
- R9: Opcodes 1100001 and 1100000 are conditional branches on N and on Z respectively. Each has one execute cycle with `rf_a`={0,sa}, `fn_sel`=0000 (pass A) and no writes, and `pc_op` is 10 when the selected flag is 1 and 01 otherwise.
- R10: Opcode 1110000 (jump) has one execute cycle with `rf_a`={0,sa}, `fn_sel`=0000, no writes and `pc_op`=11.
- R11: Any other opcode has one execute cycle with no writes, `addr_from_pc`=0, `pc_op`=01 and all other selects at 0, after which the controller fetches.
- R12: `pc_op` is 00 in every cycle of an instruction except exactly one, the last execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 7 | Opcode field from the instruction register |
| dr | input | 3 | Destination field from the instruction register |
| sa | input | 3 | Source-A field from the instruction register |
| sb | input | 3 | Source-B field from the instruction register |
| n_flag | input | 1 | Negative status from the function unit |
| z_flag | input | 1 | Zero status from the function unit |
| addr_from_pc | output | 1 | Memory address source: 1 PC, 0 bus A |
| ir_load | output | 1 | Instruction-register load enable |
| pc_op | output | 2 | PC command: 00 hold, 01 increment, 10 add offset, 11 load R[SA] |
| rf_dst | output | 4 | Register-file destination address |
| rf_a | output | 4 | Register-file A read address |
| rf_b | output | 4 | Register-file B read address |
| b_const | output | 1 | Bus B carries the constant instead of the register |
| fn_sel | output | 4 | Function-unit operation select |
| d_from_mem | output | 1 | Bus D takes memory data instead of the function unit |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Memory write enable |

## Verification
Each instruction class is run with distinct register fields so that a swapped or stuck address selector shows up in `rf_dst`, `rf_a` or `rf_b`. Add and add-immediate differ only in the bus B source, and load and store differ only in which write enable rises. Both branches are run with their own flag set and clear and with the other flag in the opposite state, so that a wrong flag choice or a wrong taken command is visible. Load-indirect is followed cycle by cycle to check the temporary address and the held PC in its first execute state. An unknown opcode checks the default path, and a reset in the middle of an instruction checks that the controller returns to fetch.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

    localparam int OPC_W = 7;
    localparam int FLD_W = 3;
    localparam int RA_W  = FLD_W + 1;
    localparam int FS_W  = 4;
    localparam int N_SEL = 3;

    typedef enum logic [1:0] {
        ST_INF = 2'd0,
        ST_EX0 = 2'd1,
        ST_EX1 = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_HOLD   = 2'd0,
        PC_INC    = 2'd1,
        PC_BRANCH = 2'd2,
        PC_JUMP   = 2'd3
    } pc_cmd_e;

    localparam logic [OPC_W-1:0] OP_ADD = 7'b0000010;
    localparam logic [OPC_W-1:0] OP_ADI = 7'b1000010;
    localparam logic [OPC_W-1:0] OP_LD  = 7'b0010000;
    localparam logic [OPC_W-1:0] OP_LRI = 7'b0010001;
    localparam logic [OPC_W-1:0] OP_ST  = 7'b0100000;
    localparam logic [OPC_W-1:0] OP_BRZ = 7'b1100000;
    localparam logic [OPC_W-1:0] OP_BRN = 7'b1100001;
    localparam logic [OPC_W-1:0] OP_JMP = 7'b1110000;

    localparam logic [FS_W-1:0] FN_PASS_A = 4'b0000;
    localparam logic [FS_W-1:0] FN_ADD    = 4'b0010;

    // first hidden temporary: top bit set, field bits clear
    localparam logic [RA_W-1:0] RA_TEMP0 = {1'b1, {FLD_W{1'b0}}};

    typedef struct packed {
        seq_state_e            ns;
        logic                  il;
        logic                  mm;
        pc_cmd_e               ps;
        logic [RA_W-1:0]       dx;
        logic [RA_W-1:0]       ax;
        logic [RA_W-1:0]       bx;
        logic                  mb;
        logic [FS_W-1:0]       fs;
        logic                  md;
        logic                  rw;
        logic                  mw;
    } ctrl_word_t;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/seq_reg_addr_sel.sv
module seq_reg_addr_sel
    import seq_ctrl_pkg::*;
#(
    parameter int FW = FLD_W,
    localparam int AW = FW + 1
) (
    input  logic [AW-1:0] ctl_field,
    input  logic [FW-1:0] ins_field,
    output logic [AW-1:0] reg_addr
);

    always_comb begin
        if (ctl_field[AW-1]) begin
            reg_addr = ctl_field;
        end else begin
            reg_addr = {1'b0, ins_field};
        end
    end

endmodule

// File: rtl/seq_ctrl_decode.sv
module seq_ctrl_decode
    import seq_ctrl_pkg::*;
(
    input  seq_state_e       state,
    input  logic [OPC_W-1:0] opcode,
    input  logic             n_flag,
    input  logic             z_flag,
    output ctrl_word_t       cw
);

    always_comb begin
        cw    = '0;
        cw.ns = ST_INF;
        cw.ps = PC_HOLD;
        unique case (state)
            ST_INF: begin
                cw.il = 1'b1;
                cw.mm = 1'b1;
                cw.ns = ST_EX0;
            end
            ST_EX0: begin
                cw.ps = PC_INC;
                case (opcode)
                    OP_ADD: begin
                        cw.fs = FN_ADD;
                        cw.rw = 1'b1;
                    end
                    OP_ADI: begin
                        cw.fs = FN_ADD;
                        cw.mb = 1'b1;
                        cw.rw = 1'b1;
                    end
                    OP_LD: begin
                        cw.md = 1'b1;
                        cw.rw = 1'b1;
                    end
                    OP_ST: begin
                        cw.mw = 1'b1;
                    end
                    OP_LRI: begin
                        cw.dx = RA_TEMP0;
                        cw.md = 1'b1;
                        cw.rw = 1'b1;
                        cw.ps = PC_HOLD;
                        cw.ns = ST_EX1;
                    end
                    OP_BRN: begin
                        cw.fs = FN_PASS_A;
                        cw.ps = n_flag ? PC_BRANCH : PC_INC;
                    end
                    OP_BRZ: begin
                        cw.fs = FN_PASS_A;
                        cw.ps = z_flag ? PC_BRANCH : PC_INC;
                    end
                    OP_JMP: begin
                        cw.fs = FN_PASS_A;
                        cw.ps = PC_JUMP;
                    end
                    default: begin
                        cw.ps = PC_INC;
                    end
                endcase
            end
            ST_EX1: begin
                cw.ax = RA_TEMP0;
                cw.md = 1'b1;
                cw.rw = 1'b1;
                cw.ps = PC_INC;
            end
            default: begin
                cw.ns = ST_INF;
            end
        endcase
    end

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
    import seq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FLD_W-1:0] dr,
    input  logic [FLD_W-1:0] sa,
    input  logic [FLD_W-1:0] sb,
    input  logic             n_flag,
    input  logic             z_flag,
    output logic             addr_from_pc,
    output logic             ir_load,
    output logic [1:0]       pc_op,
    output logic [RA_W-1:0]  rf_dst,
    output logic [RA_W-1:0]  rf_a,
    output logic [RA_W-1:0]  rf_b,
    output logic             b_const,
    output logic [FS_W-1:0]  fn_sel,
    output logic             d_from_mem,
    output logic             rf_we,
    output logic             mem_we
);

    seq_regs_t  regs_d, regs_q;
    ctrl_word_t cw;

    logic [RA_W-1:0]  ctl_sel  [N_SEL];
    logic [FLD_W-1:0] ins_sel  [N_SEL];
    logic [RA_W-1:0]  addr_out [N_SEL];

    seq_ctrl_decode u_decode (
        .state  (regs_q.state),
        .opcode (opcode),
        .n_flag (n_flag),
        .z_flag (z_flag),
        .cw     (cw)
    );

    always_comb begin
        ctl_sel[0] = cw.dx;
        ctl_sel[1] = cw.ax;
        ctl_sel[2] = cw.bx;
        ins_sel[0] = dr;
        ins_sel[1] = sa;
        ins_sel[2] = sb;
    end

    for (genvar g = 0; g < N_SEL; g++) begin : g_addr
        seq_reg_addr_sel #(.FW(FLD_W)) u_sel (
            .ctl_field (ctl_sel[g]),
            .ins_field (ins_sel[g]),
            .reg_addr  (addr_out[g])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = ST_INF;
        end else begin
            regs_d.state = cw.ns;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign addr_from_pc = cw.mm;
    assign ir_load      = cw.il;
    assign pc_op        = cw.ps;
    assign rf_dst       = addr_out[0];
    assign rf_a         = addr_out[1];
    assign rf_b         = addr_out[2];
    assign b_const      = cw.mb;
    assign fn_sel       = cw.fs;
    assign d_from_mem   = cw.md;
    assign rf_we        = cw.rw;
    assign mem_we       = cw.mw;

endmodule

// File: rtl/seq_ctrl_unit_chk.sv
module seq_ctrl_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] state,
    input logic [6:0] opcode,
    input logic       n_flag,
    input logic       addr_from_pc,
    input logic       ir_load,
    input logic [1:0] pc_op,
    input logic [3:0] rf_dst,
    input logic [3:0] rf_a,
    input logic       rf_we,
    input logic       mem_we
);

    logic [1:0] upd_cnt;
    logic       seen_fetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_cnt    <= '0;
            seen_fetch <= 1'b0;
        end else if (ir_load) begin
            upd_cnt    <= '0;
            seen_fetch <= 1'b1;
        end else if (pc_op != 2'b00 && upd_cnt != 2'b11) begin
            upd_cnt <= upd_cnt + 2'd1;
        end
    end

    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> ir_load);

    assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> !ir_load);

    assert_pc_addr_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        addr_from_pc |-> (ir_load && pc_op == 2'b00));

    assert_no_dual_write_R7: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && mem_we));

    assert_temp_step_R8: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2) |-> ($past(rf_dst) == 4'b1000 && rf_a == 4'b1000));

    assert_brn_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && opcode == 7'b1100001 && n_flag) |-> pc_op == 2'b10);

    assert_one_update_R12: assert property (@(posedge clk) disable iff (rst)
        (ir_load && seen_fetch) |-> upd_cnt == 2'd1);

endmodule

bind seq_ctrl_unit seq_ctrl_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (regs_q.state),
    .opcode       (opcode),
    .n_flag       (n_flag),
    .addr_from_pc (addr_from_pc),
    .ir_load      (ir_load),
    .pc_op        (pc_op),
    .rf_dst       (rf_dst),
    .rf_a         (rf_a),
    .rf_we        (rf_we),
    .mem_we       (mem_we)
);

// File: tb/seq_ctrl_unit_test.sv
module seq_ctrl_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode = '0;
    logic [2:0] dr = '0, sa = '0, sb = '0;
    logic       n_flag = 1'b0, z_flag = 1'b0;
    logic       addr_from_pc, ir_load, b_const, d_from_mem, rf_we, mem_we;
    logic [1:0] pc_op;
    logic [3:0] rf_dst, rf_a, rf_b, fn_sel;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    seq_ctrl_unit uut (
        .clk(clk), .rst(rst), .opcode(opcode), .dr(dr), .sa(sa), .sb(sb),
        .n_flag(n_flag), .z_flag(z_flag), .addr_from_pc(addr_from_pc),
        .ir_load(ir_load), .pc_op(pc_op), .rf_dst(rf_dst), .rf_a(rf_a),
        .rf_b(rf_b), .b_const(b_const), .fn_sel(fn_sel),
        .d_from_mem(d_from_mem), .rf_we(rf_we), .mem_we(mem_we)
    );

    function automatic logic [23:0] mk(input logic mm, input logic il,
                                       input logic [1:0] ps, input logic [3:0] da,
                                       input logic [3:0] aa, input logic [3:0] ba,
                                       input logic mb, input logic [3:0] fs,
                                       input logic md, input logic rw, input logic mw);
        return {mm, il, ps, da, aa, ba, mb, fs, md, rw, mw};
    endfunction

    task automatic check(input string tag, input logic [23:0] exp);
        logic [23:0] act;
        act = {addr_from_pc, ir_load, pc_op, rf_dst, rf_a, rf_b,
               b_const, fn_sel, d_from_mem, rf_we, mem_we};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ins(input logic [6:0] op, input logic [2:0] d,
                           input logic [2:0] a, input logic [2:0] b,
                           input logic n, input logic z);
        opcode = op; dr = d; sa = a; sb = b; n_flag = n; z_flag = z;
    endtask

    // entry: just after a falling edge in a fetch cycle
    task automatic fetch_check(input string tag);
        #1;
        check({tag, " R2 fetch"}, mk(1, 1, 2'b00, {1'b0, dr}, {1'b0, sa},
                                     {1'b0, sb}, 0, 4'b0000, 0, 0, 0));
        @(negedge clk);
    endtask

    task automatic run_single(input string tag, input logic [23:0] exp_ex);
        fetch_check(tag);
        #1;
        check(tag, exp_ex);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 after reset", mk(1, 1, 2'b00, 4'h0, 4'h0, 4'h0, 0, 4'b0000, 0, 0, 0));
    endtask

    task automatic t_add;
        set_ins(7'b0000010, 3'd5, 3'd2, 3'd7, 0, 0);
        run_single("R4 R3 add", mk(0, 0, 2'b01, 4'd5, 4'd2, 4'd7, 0, 4'b0010, 0, 1, 0));
    endtask

    task automatic t_adi;
        set_ins(7'b1000010, 3'd1, 3'd6, 3'd3, 1, 1);
        run_single("R5 add immediate", mk(0, 0, 2'b01, 4'd1, 4'd6, 4'd3, 1, 4'b0010, 0, 1, 0));
    endtask

    task automatic t_ld;
        set_ins(7'b0010000, 3'd4, 3'd3, 3'd0, 0, 0);
        run_single("R6 load", mk(0, 0, 2'b01, 4'd4, 4'd3, 4'd0, 0, 4'b0000, 1, 1, 0));
    endtask

    task automatic t_st;
        set_ins(7'b0100000, 3'd0, 3'd3, 3'd2, 0, 0);
        run_single("R7 store", mk(0, 0, 2'b01, 4'd0, 4'd3, 4'd2, 0, 4'b0000, 0, 0, 1));
    endtask

    task automatic t_lri;
        set_ins(7'b0010001, 3'd6, 3'd5, 3'd1, 0, 0);
        fetch_check("R8 lri");
        #1;
        check("R8 R3 lri first step", mk(0, 0, 2'b00, 4'd8, 4'd5, 4'd1, 0, 4'b0000, 1, 1, 0));
        @(negedge clk);
        #1;
        check("R8 R12 lri second step", mk(0, 0, 2'b01, 4'd6, 4'd8, 4'd1, 0, 4'b0000, 1, 1, 0));
        @(negedge clk);
        #1;
        check("R8 fetch after lri", mk(1, 1, 2'b00, 4'd6, 4'd5, 4'd1, 0, 4'b0000, 0, 0, 0));
    endtask

    task automatic t_branch(input logic [6:0] op, input logic n, input logic z,
                            input logic [1:0] exp_ps, input string tag);
        set_ins(op, 3'd2, 3'd7, 3'd4, n, z);
        run_single(tag, mk(0, 0, exp_ps, 4'd2, 4'd7, 4'd4, 0, 4'b0000, 0, 0, 0));
    endtask

    task automatic t_jmp;
        set_ins(7'b1110000, 3'd3, 3'd1, 3'd6, 1, 1);
        run_single("R10 jump", mk(0, 0, 2'b11, 4'd3, 4'd1, 4'd6, 0, 4'b0000, 0, 0, 0));
    endtask

    task automatic t_unknown;
        set_ins(7'b0111111, 3'd7, 3'd7, 3'd7, 1, 1);
        run_single("R11 unknown opcode", mk(0, 0, 2'b01, 4'd7, 4'd7, 4'd7, 0, 4'b0000, 0, 0, 0));
        #1;
        check("R11 fetch after unknown", mk(1, 1, 2'b00, 4'd7, 4'd7, 4'd7, 0, 4'b0000, 0, 0, 0));
    endtask

    task automatic t_reset_mid;
        set_ins(7'b0010001, 3'd2, 3'd3, 3'd4, 0, 0);
        fetch_check("R1 mid");
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R1 reset during execute", mk(1, 1, 2'b00, 4'd2, 4'd3, 4'd4, 0, 4'b0000, 0, 0, 0));
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_adi();
        t_ld();
        t_st();
        t_lri();
        t_branch(7'b1100001, 1, 0, 2'b10, "R9 brn taken");
        t_branch(7'b1100001, 0, 1, 2'b01, "R9 brn not taken");
        t_branch(7'b1100000, 0, 1, 2'b10, "R9 brz taken");
        t_branch(7'b1100000, 1, 0, 2'b01, "R9 brz not taken");
        t_jmp();
        t_unknown();
        t_reset_mid();
        t_add();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule